// File: doc/BRIEF.md
# Clock Synthesizer Configuration Store

This block holds the configuration word of a crystal-based clock synthesizer and presents one active copy of it to the loop counters, post-divider, output driver and tuning array. It has two write-once rows that model one-time-programmable storage, and one volatile shadow register. A simple programming port either rewrites the shadow, which can be done any number of times while tuning a part on the bench, or burns one row. Burning a row stores the word and sets that row's valid bit for good.

The same hardware serves two variants, chosen by a static input. In reprogram mode the second row lets a burned configuration be replaced exactly once, and the highest burned row wins. In frequency-select mode each row holds one of two alternate frequencies, and a pin picks between them. The pin is registered, and the whole output word is updated in one register, so a switch never shows a mix of two words. A build parameter can remove the shadow; the block then uses only the burned rows. The output also gives the effective feedback and reference loop counts, P+5 and Q+2, used in F_out = F_ref x 2(P+5)/(Q+2).

Top module: `clkcfg_store`

## Requirements
- R1: After reset, every row is unburned, `burn_err` is low and `cfg_word` is all zeros. `act_src` then reads 1 (shadow) with the shadow enabled, or 0 (none) without it.
- R2: While no row is burned, a shadow write (`prg_op`=1) is captured on the next clock edge and appears on `cfg_word` one edge later, with `act_src`=1. Repeated writes are allowed, and the last one wins.
- R3: A burn (`prg_op`=2) of an unburned row stores `prg_word` into the row named by `prg_row` and sets that row's bit in `row_valid`, which never clears again. In reprogram mode, once row 0 is the active source, later shadow writes have no effect on `cfg_word`.
- R4: A burn aimed at a row whose valid bit is already set raises `burn_err` for exactly one cycle, on the edge after the request. The stored row contents and `cfg_word` stay unchanged.
- R5: In reprogram mode (`mode_fsel`=0) the active source is the highest-numbered burned row: row 1 (`act_src`=3) if burned, else row 0 (`act_src`=2), else the shadow.
- R6: In frequency-select mode (`mode_fsel`=1), `fsel_pin`=0 selects row 0 and `fsel_pin`=1 selects row 1. A pin change is seen at the output two edges later, and after the first edge the output still holds the full previous word.
- R7: In frequency-select mode, if the selected row is not burned, the output falls back to the shadow, or to the all-zero word with `act_src`=0 when the shadow is disabled.
- R8: The word layout, from the LSB, is: feedback count P [11:0], reference count Q [21:12], post-divider select [24:22], source select [25] (1 = reference), tuning bits [32:26], duty level [33] (1 = CMOS), power mode [34] (1 = output enable), and timing [35] (1 = synchronous). `p_eff` = P+5 (13 bits) and `q_eff` = Q+2 (11 bits).
- R9: With `SHADOW_EN`=0, shadow writes are ignored and `act_src` never reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_fsel | input | 1 | 0 = reprogram variant, 1 = frequency-select variant |
| fsel_pin | input | 1 | Row choice in frequency-select mode |
| prg_op | input | 2 | 0 idle, 1 shadow write, 2 burn row, 3 ignored |
| prg_row | input | 1 | Row targeted by a burn |
| prg_word | input | 36 | Configuration word to write or burn |
| cfg_word | output | 36 | Active configuration word |
| p_eff | output | 13 | Effective feedback count P+5 |
| q_eff | output | 11 | Effective reference count Q+2 |
| act_src | output | 2 | Active source: 0 none, 1 shadow, 2 row 0, 3 row 1 |
| row_valid | output | 2 | Burned flag of each row |
| burn_err | output | 1 | One-cycle pulse on a rejected re-burn |

## Verification
The checker watches four things on every cycle: that valid bits never clear, that each re-burn request is flagged on the next cycle, that a burned row 1 takes over in reprogram mode, and that a shadow write reaches the output two edges later while nothing is burned. It also checks that a shadow-less build never reports the shadow as source. The bench scenarios cover the rest. They show that a rejected burn leaves the earlier contents in place, that shadow writes are blocked once a row is committed, and that the fall-back to the shadow works when the pin picks an empty row. They also show the two-edge whole-word switch on a pin change and the arithmetic on the effective loop counts at the extreme field values.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int FB_W   = 12;
    localparam int RC_W   = 10;
    localparam int DIV_W  = 3;
    localparam int TUNE_W = 7;
    localparam int FB_OFS = 5;
    localparam int RC_OFS = 2;
    localparam int NROWS  = 2;
    localparam int ROW_W  = $clog2(NROWS);

    // Declared MSB first: fb_cnt occupies the low bits
    typedef struct packed {
        logic              pm_sync;
        logic              pm_oe;
        logic              duty_cmos;
        logic [TUNE_W-1:0] tune;
        logic              src_ref;
        logic [DIV_W-1:0]  post_div;
        logic [RC_W-1:0]   ref_cnt;
        logic [FB_W-1:0]   fb_cnt;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_SHADOW = 2'd1,
        SRC_ROW0   = 2'd2,
        SRC_ROW1   = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_SHADOW = 2'd1,
        OP_BURN   = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

endpackage

// File: rtl/clkcfg_otp_row.sv
module clkcfg_otp_row
    import clkcfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic burn_req,
    input  cfg_t din,
    output logic valid,
    output cfg_t data,
    output logic reject
);

    typedef struct packed {
        logic valid;
        cfg_t data;
    } row_st_t;

    row_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        reject = burn_req && st_q.valid;
        if (burn_req && !st_q.valid) begin
            st_d.valid = 1'b1;
            st_d.data  = din;
        end
    end

    // Reset stands in for a blank part at power-up in this model
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign data  = st_q.data;

endmodule

// File: rtl/clkcfg_shadow.sv
module clkcfg_shadow
    import clkcfg_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  cfg_t din,
    output cfg_t dout
);

    generate
        if (ENABLE) begin : g_on
            cfg_t sh_d, sh_q;

            always_comb begin
                sh_d = sh_q;
                if (wr_en) sh_d = din;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= sh_d;
            end

            assign dout = sh_q;
        end else begin : g_off
            logic unused_sh;
            assign unused_sh = ^{clk, rst_n, wr_en, din};
            assign dout      = '0;
        end
    endgenerate

endmodule

// File: rtl/clkcfg_sel.sv
module clkcfg_sel
    import clkcfg_pkg::*;
#(
    parameter bit SHADOW_EN = 1'b1
) (
    input  logic             mode_fsel,
    input  logic             fs_sync,
    input  logic [NROWS-1:0] valid,
    input  cfg_t             row0,
    input  cfg_t             row1,
    input  cfg_t             shadow,
    output cfg_t             word,
    output src_e             src
);

    logic use_row;
    logic pick;

    always_comb begin
        if (mode_fsel) begin
            pick    = fs_sync;
            use_row = valid[fs_sync];
        end else begin
            pick    = valid[1];
            use_row = |valid;
        end

        if (use_row) begin
            word = pick ? row1 : row0;
            src  = pick ? SRC_ROW1 : SRC_ROW0;
        end else if (SHADOW_EN) begin
            word = shadow;
            src  = SRC_SHADOW;
        end else begin
            word = '0;
            src  = SRC_NONE;
        end
    end

endmodule

// File: rtl/clkcfg_store.sv
module clkcfg_store
    import clkcfg_pkg::*;
#(
    parameter bit SHADOW_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_fsel,
    input  logic             fsel_pin,
    input  logic [1:0]       prg_op,
    input  logic [ROW_W-1:0] prg_row,
    input  logic [CFG_W-1:0] prg_word,
    output logic [CFG_W-1:0] cfg_word,
    output logic [FB_W:0]    p_eff,
    output logic [RC_W:0]    q_eff,
    output logic [1:0]       act_src,
    output logic [NROWS-1:0] row_valid,
    output logic             burn_err
);

    typedef struct packed {
        logic fs;
        cfg_t cfg;
        src_e src;
        logic err;
    } top_st_t;

    top_st_t st_d, st_q;

    cfg_t             wr_word;
    cfg_t             row_data [NROWS];
    logic [NROWS-1:0] row_rej;
    cfg_t             sh_word;
    cfg_t             sel_word;
    src_e             sel_src;

    assign wr_word = cfg_t'(prg_word);

    generate
        for (genvar r = 0; r < NROWS; r++) begin : g_row
            clkcfg_otp_row u_row (
                .clk      (clk),
                .rst_n    (rst_n),
                .burn_req ((prg_op == OP_BURN) && (prg_row == ROW_W'(r))),
                .din      (wr_word),
                .valid    (row_valid[r]),
                .data     (row_data[r]),
                .reject   (row_rej[r])
            );
        end
    endgenerate

    clkcfg_shadow #(.ENABLE(SHADOW_EN)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (prg_op == OP_SHADOW),
        .din   (wr_word),
        .dout  (sh_word)
    );

    clkcfg_sel #(.SHADOW_EN(SHADOW_EN)) u_sel (
        .mode_fsel (mode_fsel),
        .fs_sync   (st_q.fs),
        .valid     (row_valid),
        .row0      (row_data[0]),
        .row1      (row_data[1]),
        .shadow    (sh_word),
        .word      (sel_word),
        .src       (sel_src)
    );

    always_comb begin
        st_d     = st_q;
        st_d.fs  = fsel_pin;
        st_d.cfg = sel_word;
        st_d.src = sel_src;
        st_d.err = |row_rej;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_word = st_q.cfg;
    assign act_src  = st_q.src;
    assign burn_err = st_q.err;
    assign p_eff    = {1'b0, st_q.cfg.fb_cnt} + (FB_W+1)'(FB_OFS);
    assign q_eff    = {1'b0, st_q.cfg.ref_cnt} + (RC_W+1)'(RC_OFS);

endmodule

// File: rtl/clkcfg_store_chk.sv
module clkcfg_store_chk
    import clkcfg_pkg::*;
#(
    parameter bit SHADOW_EN = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_fsel,
    input logic [1:0]       prg_op,
    input logic [ROW_W-1:0] prg_row,
    input logic [CFG_W-1:0] prg_word,
    input logic [CFG_W-1:0] cfg_word,
    input logic [1:0]       act_src,
    input logic [NROWS-1:0] row_valid,
    input logic             burn_err
);

    // R3
    row0_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid[0] |=> row_valid[0]);

    // R3
    row1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid[1] |=> row_valid[1]);

    // R4
    reburn_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_op == 2'd2 && row_valid[prg_row]) |=> burn_err);

    // R4
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burn_err |-> $past(prg_op) == 2'd2);

    // R5
    top_row_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_fsel && row_valid[1]) |=> act_src == 2'd3);

    // R2
    shadow_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SHADOW_EN && prg_op == 2'd1 && row_valid == '0)
            |=> ##1 cfg_word == $past(prg_word, 2));

    // R9
    no_shadow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SHADOW_EN == 1'b0) |-> act_src != 2'd1);

endmodule

bind clkcfg_store clkcfg_store_chk #(.SHADOW_EN(SHADOW_EN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_fsel (mode_fsel),
    .prg_op    (prg_op),
    .prg_row   (prg_row),
    .prg_word  (prg_word),
    .cfg_word  (cfg_word),
    .act_src   (act_src),
    .row_valid (row_valid),
    .burn_err  (burn_err)
);

// File: tb/tb_clkcfg_store.sv
module tb_clkcfg_store;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_fsel = 1'b0;
    logic        fsel_pin = 1'b0;
    logic [1:0]  prg_op = 2'd0;
    logic        prg_row = 1'b0;
    logic [35:0] prg_word = '0;

    logic [35:0] cfg_word, cfg_word_ns;
    logic [12:0] p_eff, p_eff_ns;
    logic [10:0] q_eff, q_eff_ns;
    logic [1:0]  act_src, act_src_ns;
    logic [1:0]  row_valid, row_valid_ns;
    logic        burn_err, burn_err_ns;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clkcfg_store #(.SHADOW_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .mode_fsel(mode_fsel), .fsel_pin(fsel_pin),
        .prg_op(prg_op), .prg_row(prg_row), .prg_word(prg_word),
        .cfg_word(cfg_word), .p_eff(p_eff), .q_eff(q_eff),
        .act_src(act_src), .row_valid(row_valid), .burn_err(burn_err)
    );

    clkcfg_store #(.SHADOW_EN(1'b0)) dut_ns (
        .clk(clk), .rst_n(rst_n), .mode_fsel(mode_fsel), .fsel_pin(fsel_pin),
        .prg_op(prg_op), .prg_row(prg_row), .prg_word(prg_word),
        .cfg_word(cfg_word_ns), .p_eff(p_eff_ns), .q_eff(q_eff_ns),
        .act_src(act_src_ns), .row_valid(row_valid_ns), .burn_err(burn_err_ns)
    );

    function automatic logic [35:0] mk(input logic [11:0] p, input logic [9:0] q,
                                       input logic [2:0] dv, input logic sr,
                                       input logic [6:0] tn, input logic dc,
                                       input logic oe, input logic sy);
        return {sy, oe, dc, tn, sr, dv, q, p};
    endfunction

    localparam logic [35:0] W1 = {1'b1, 1'b0, 1'b1, 7'h11, 1'b0, 3'd3, 10'h045, 12'h123};
    localparam logic [35:0] W3 = {1'b0, 1'b0, 1'b0, 7'h05, 1'b1, 3'd1, 10'h00A, 12'h010};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic row, input logic [35:0] w);
        @(negedge clk);
        prg_op = op; prg_row = row; prg_word = w;
        @(negedge clk);
        prg_op = 2'd0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 word", cfg_word, 0);
        chk("R1 src", act_src, 1);
        chk("R1 valid", row_valid, 0);
        chk("R1 err", burn_err, 0);
        chk("R1 src no-shadow", act_src_ns, 0);
    endtask

    task automatic t_shadow();
        logic [35:0] w2;
        w2 = mk(12'hFFF, 10'h3FF, 3'd7, 1'b1, 7'h7F, 1'b0, 1'b1, 1'b0);
        do_op(2'd1, 1'b0, W1);
        @(negedge clk);
        chk("R2 first write", cfg_word, W1);
        do_op(2'd1, 1'b0, w2);
        @(negedge clk);
        chk("R2 rewrite", cfg_word, w2);
        chk("R2 src", act_src, 1);
        chk("R8 p_eff max", p_eff, 13'd4100);
        chk("R8 q_eff max", q_eff, 11'd1025);
        chk("R8 post_div field", cfg_word[24:22], 3'd7);
        chk("R9 word ignored", cfg_word_ns, 0);
        chk("R9 src none", act_src_ns, 0);
        do_op(2'd1, 1'b0, W3);
        @(negedge clk);
        chk("R8 p_eff", p_eff, 13'd21);
        chk("R8 q_eff", q_eff, 11'd12);
    endtask

    task automatic t_burn0(input logic [35:0] a);
        do_op(2'd2, 1'b0, a);
        @(negedge clk);
        chk("R3 word", cfg_word, a);
        chk("R3 src", act_src, 2);
        chk("R3 valid", row_valid, 2'b01);
        chk("R9 burned row used", cfg_word_ns, a);
        do_op(2'd1, 1'b0, W1);
        @(negedge clk);
        chk("R3 shadow blocked", cfg_word, a);
    endtask

    task automatic t_reburn(input logic row, input logic [35:0] b, input logic [35:0] keep);
        do_op(2'd2, row, b);
        chk("R4 err pulse", burn_err, 1);
        @(negedge clk);
        chk("R4 err one cycle", burn_err, 0);
        chk("R4 word kept", cfg_word, keep);
    endtask

    task automatic t_fsel_fallback(input logic [35:0] a);
        @(negedge clk);
        mode_fsel = 1'b1; fsel_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 shadow fallback", cfg_word, W1);
        chk("R7 src", act_src, 1);
        chk("R7 no-shadow zero", cfg_word_ns, 0);
        chk("R7 no-shadow src", act_src_ns, 0);
        fsel_pin = 1'b0;
        @(negedge clk);
        chk("R6 hold after one edge", cfg_word, W1);
        @(negedge clk);
        chk("R6 row0", cfg_word, a);
        chk("R6 row0 src", act_src, 2);
    endtask

    task automatic t_row1(input logic [35:0] c);
        @(negedge clk);
        mode_fsel = 1'b0;
        do_op(2'd2, 1'b1, c);
        @(negedge clk);
        chk("R5 row1 wins", cfg_word, c);
        chk("R5 src", act_src, 3);
        chk("R5 valid", row_valid, 2'b11);
    endtask

    task automatic t_fsel_swap(input logic [35:0] a, input logic [35:0] c);
        @(negedge clk);
        mode_fsel = 1'b1; fsel_pin = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 fs0", cfg_word, a);
        fsel_pin = 1'b1;
        @(negedge clk);
        chk("R6 whole word held", cfg_word, a);
        @(negedge clk);
        chk("R6 fs1", cfg_word, c);
        chk("R6 fs1 src", act_src, 3);
    endtask

    initial begin
        logic [35:0] wa, wb, wc;
        wa = mk(12'h000, 10'h000, 3'd0, 1'b0, 7'h01, 1'b1, 1'b1, 1'b1);
        wb = mk(12'hABC, 10'h155, 3'd5, 1'b1, 7'h2A, 1'b0, 1'b0, 1'b0);
        wc = mk(12'h800, 10'h200, 3'd4, 1'b0, 7'h40, 1'b1, 1'b0, 1'b1);
        t_reset();
        t_shadow();
        t_burn0(wa);
        chk("R8 p_eff min", p_eff, 13'd5);
        chk("R8 q_eff min", q_eff, 11'd2);
        t_reburn(1'b0, wb, wa);
        t_fsel_fallback(wa);
        t_row1(wc);
        t_reburn(1'b1, wb, wc);
        t_fsel_swap(wa, wc);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule